// File: doc/BRIEF.md
# Dual-Channel Result Readout Port

This block holds the latest pair of 16-bit conversion results from two channels, A and B, which are sampled at the same instant. It hands them to a host over one of two interfaces. A new pair arrives on a valid-strobed input. The block latches the pair together with a one-bit tag that records which analog input pair was sampled.

With the serial select low, the host reads a parallel word. The word is gated by active-low chip-select and read inputs. A channel select picks A or B, and a byte-swap control lets an 8-bit host take the word in two halves. The bus drives data and a separate enable, and the pad drivers sit outside the block.

With the serial select high, the arrival of each new pair starts a 32-bit frame. The frame carries both results, most significant bit first, with the channel select deciding which channel goes first. In master clocking the block divides its own clock to make the serial clock and drives a framing signal whose polarity can be set. In slave clocking a host clock shifts the frame and the divider setting has no effect.

Top module: `dual_result_port`

## Requirements
- R1: When res_valid is high at a rising clk edge, res_a, res_b and pair_sel are latched, and pair_tag equals the latched pair_sel from the following cycle on.
- R2: data_oe is high only when ser_mode=0, cs_n=0 and rd_n=0. Otherwise it is low and data_out is zero.
- R3: When the parallel bus is enabled, the word is the latched channel A result if chan_a_sel=1 and the latched channel B result if chan_a_sel=0.
- R4: With swap_bytes=0 the word appears as is (low byte on data_out[7:0]). With swap_bytes=1 the low byte is on data_out[15:8] and the high byte is on data_out[7:0].
- R5: In serial mode (ser_mode=1) each res_valid starts a 32-bit frame, sent most significant bit first. The frame is {A,B} when chan_a_sel=1 and {B,A} when chan_a_sel=0.
- R6: In master clocking (ext_clk_sel=0) with divider value N on div_set, sclk_out starts low at the start edge and first rises 2^N clk cycles later. It then has a period of 2^(N+1) cycles and 32 rising edges per frame. sdout changes only while sclk_out is low, so each bit is valid at a rising edge of sclk_out.
- R7: In master clocking, sync is asserted from the start edge until the 32nd falling edge of sclk_out, which is 64*2^N cycles. It is active high when sync_inv=0 and active low when sync_inv=1.
- R8: In slave clocking (ext_clk_sel=1), sdout shows frame bit 31 after the start. Each rising edge of sclk_in, passed through a two-flop synchronizer, advances one bit. After 32 rising edges the frame ends and sdout is 0.
- R9: In slave clocking, sclk_out and sync stay low whatever sync_inv is, and div_set has no effect on the bits shifted out.
- R10: After reset, data_oe, data_out, sdout, sclk_out, sync and pair_tag are all 0 (with sync_inv=0 and cs_n=1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_valid | input | 1 | Strobe: new result pair present |
| res_a | input | 16 | Channel A result |
| res_b | input | 16 | Channel B result |
| pair_sel | input | 1 | Sampled input pair (0 = pair 1, 1 = pair 2) |
| ser_mode | input | 1 | 0 = parallel bus, 1 = serial port |
| chan_a_sel | input | 1 | Parallel: 1 reads A. Serial: 1 sends A first |
| swap_bytes | input | 1 | Exchange the two bytes of the parallel word |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read |
| ext_clk_sel | input | 1 | 0 = master serial clock, 1 = host serial clock |
| sync_inv | input | 1 | 0 = sync active high, 1 = active low |
| div_set | input | 2 | Master serial clock divider value N |
| sclk_in | input | 1 | Host serial clock (slave) |
| data_out | output | 16 | Parallel word |
| data_oe | output | 1 | Parallel bus drive enable |
| pair_tag | output | 1 | Pair tag stored with the results |
| sdout | output | 1 | Serial data |
| sclk_out | output | 1 | Serial clock out (master) |
| sync | output | 1 | Frame marker (master) |

## Verification
The hardest behaviour to reach is the full timing of a master frame at the slowest divider. The first rising edge, the spacing of every edge and the exact length of the frame marker must all line up. This has to hold across every polarity and channel order. The bench starts one frame for each combination of divider value, order and polarity. It watches the port at every cycle and rebuilds the 32 bits from the rising edges it sees. The slave path is driven with a slow host clock that leaves room for the synchronizer, and it is repeated at two divider settings to show the setting has no effect.

// File: rtl/drp_pkg.sv
// Shared types for the dual result readout port.
// Assumes a 16-bit result width for the default configuration.
package drp_pkg;
    localparam int unsigned RES_W = 16;

    typedef struct packed {
        logic [RES_W-1:0] a;
        logic [RES_W-1:0] b;
        logic             tag;
    } res_pair_t;
endpackage

// File: rtl/drp_par_mux.sv
// Parallel word former: picks a channel and optionally exchanges bytes.
// Assumes DW is even; purely combinational.
module drp_par_mux #(
    parameter int unsigned DW = 16
) (
    input  logic [DW-1:0] ra,
    input  logic [DW-1:0] rb,
    input  logic          chan_a_sel,
    input  logic          swap_bytes,
    output logic [DW-1:0] word
);
    localparam int unsigned HW = DW / 2;

    logic [DW-1:0] pick;

    // channel choice then byte order
    always_comb begin
        pick = chan_a_sel ? ra : rb;
        word = swap_bytes ? {pick[HW-1:0], pick[DW-1:HW]} : pick;
    end
endmodule

// File: rtl/drp_ser_engine.sv
// Serial frame engine: shifts a 2*DW frame MSB first on either a divided
// internal clock (master) or a synchronized host clock (slave).
// Assumes sclk_in is slower than clk/4 in each phase.
module drp_ser_engine #(
    parameter int unsigned DW    = 16,
    parameter int unsigned DIV_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [2*DW-1:0] frame,
    input  logic            ext_clk_sel,
    input  logic            sync_inv,
    input  logic [DIV_W-1:0] div_set,
    input  logic            sclk_in,
    output logic            sdout,
    output logic            sclk_out,
    output logic            sync
);
    localparam int unsigned FW    = 2 * DW;
    localparam int unsigned BC_W  = $clog2(FW);
    localparam int unsigned CNT_W = (1 << DIV_W) - 1;
    localparam logic [BC_W-1:0] LAST = BC_W'(FW - 1);

    logic              active_q;
    logic              ext_q;
    logic [DIV_W-1:0]  div_q;
    logic [CNT_W-1:0]  div_cnt;
    logic              sclk_q;
    logic [BC_W-1:0]   bit_cnt;
    logic [FW-1:0]     shreg;
    logic              s_meta, s_sync, s_prev;
    logic              host_rise;
    logic [CNT_W:0]    span;
    logic [CNT_W:0]    lim_w;
    logic              tick;

    // divider compare value from the latched setting
    always_comb begin
        span  = (CNT_W+1)'(1) << div_q;
        lim_w = span - (CNT_W+1)'(1);
        tick  = (div_cnt == lim_w[CNT_W-1:0]);
    end

    // two-flop synchronizer and edge history for the host clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_meta <= 1'b0;
            s_sync <= 1'b0;
            s_prev <= 1'b0;
        end else begin
            s_meta <= sclk_in;
            s_sync <= s_meta;
            s_prev <= s_sync;
        end
    end

    assign host_rise = s_sync & ~s_prev;

    // frame state: load on start, advance on clock events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            ext_q    <= 1'b0;
            div_q    <= '0;
            div_cnt  <= '0;
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            ext_q    <= ext_clk_sel;
            div_q    <= div_set;
            div_cnt  <= '0;
            sclk_q   <= 1'b0;
            bit_cnt  <= '0;
            shreg    <= frame;
        end else if (active_q) begin
            if (!ext_q) begin
                if (tick) begin
                    div_cnt <= '0;
                    sclk_q  <= ~sclk_q;
                    if (sclk_q) begin
                        shreg <= shreg << 1;
                        if (bit_cnt == LAST) active_q <= 1'b0;
                        else                 bit_cnt  <= bit_cnt + 1'b1;
                    end
                end else begin
                    div_cnt <= div_cnt + 1'b1;
                end
            end else if (host_rise) begin
                shreg <= shreg << 1;
                if (bit_cnt == LAST) active_q <= 1'b0;
                else                 bit_cnt  <= bit_cnt + 1'b1;
            end
        end
    end

    // output shaping: master-only clock and marker
    always_comb begin
        sdout    = active_q & shreg[FW-1];
        sclk_out = sclk_q & ~ext_q & ~ext_clk_sel;
        sync     = ext_clk_sel ? 1'b0 : ((active_q & ~ext_q) ^ sync_inv);
    end
endmodule

// File: rtl/dual_result_port.sv
// Top: latches a result pair with its tag and presents it on a gated
// parallel word or a serial frame. Assumes res_valid is a one-cycle strobe.
module dual_result_port #(
    parameter int unsigned DW    = drp_pkg::RES_W,
    parameter int unsigned DIV_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             res_valid,
    input  logic [DW-1:0]    res_a,
    input  logic [DW-1:0]    res_b,
    input  logic             pair_sel,
    input  logic             ser_mode,
    input  logic             chan_a_sel,
    input  logic             swap_bytes,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             ext_clk_sel,
    input  logic             sync_inv,
    input  logic [DIV_W-1:0] div_set,
    input  logic             sclk_in,
    output logic [DW-1:0]    data_out,
    output logic             data_oe,
    output logic             pair_tag,
    output logic             sdout,
    output logic             sclk_out,
    output logic             sync
);
    logic [DW-1:0]   ra_q, rb_q;
    logic            tag_q;
    logic [DW-1:0]   word;
    logic [2*DW-1:0] frame;
    logic            start;

    // result holding registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ra_q  <= '0;
            rb_q  <= '0;
            tag_q <= 1'b0;
        end else if (res_valid) begin
            ra_q  <= res_a;
            rb_q  <= res_b;
            tag_q <= pair_sel;
        end
    end

    drp_par_mux #(.DW(DW)) u_mux (
        .ra         (ra_q),
        .rb         (rb_q),
        .chan_a_sel (chan_a_sel),
        .swap_bytes (swap_bytes),
        .word       (word)
    );

    // parallel gating, frame order and start
    always_comb begin
        data_oe  = ~ser_mode & ~cs_n & ~rd_n;
        data_out = data_oe ? word : '0;
        frame    = chan_a_sel ? {res_a, res_b} : {res_b, res_a};
        start    = res_valid & ser_mode;
    end

    assign pair_tag = tag_q;

    drp_ser_engine #(.DW(DW), .DIV_W(DIV_W)) u_ser (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .frame       (frame),
        .ext_clk_sel (ext_clk_sel),
        .sync_inv    (sync_inv),
        .div_set     (div_set),
        .sclk_in     (sclk_in),
        .sdout       (sdout),
        .sclk_out    (sclk_out),
        .sync        (sync)
    );
endmodule

// File: rtl/dual_result_port_chk.sv
// Checker for dual_result_port, attached through bind below.
module dual_result_port_chk (
    input logic clk,
    input logic rst_n,
    input logic res_valid,
    input logic pair_sel,
    input logic ser_mode,
    input logic cs_n,
    input logic rd_n,
    input logic sync_inv,
    input logic data_oe,
    input logic pair_tag,
    input logic sdout,
    input logic sclk_out,
    input logic sync
);
    // R1: tag follows the strobed pair select
    a_r1_tag_capture: assert property (@(posedge clk) disable iff (!rst_n)
        $past(res_valid) |-> (pair_tag == $past(pair_sel)));

    // R2: bus never enabled outside a parallel read
    a_r2_oe_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_mode || cs_n || rd_n) |-> !data_oe);

    // R6: data holds while the serial clock stays high
    a_r6_data_stable_high: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_out && $past(sclk_out)) |-> $stable(sdout));

    // R7: clock edges only inside an asserted frame marker
    a_r7_clock_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_out) |-> (sync != sync_inv));
endmodule

bind dual_result_port dual_result_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .res_valid (res_valid),
    .pair_sel  (pair_sel),
    .ser_mode  (ser_mode),
    .cs_n      (cs_n),
    .rd_n      (rd_n),
    .sync_inv  (sync_inv),
    .data_oe   (data_oe),
    .pair_tag  (pair_tag),
    .sdout     (sdout),
    .sclk_out  (sclk_out),
    .sync      (sync)
);

// File: tb/dual_result_port_test.sv
module dual_result_port_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        res_valid = 1'b0;
    logic [15:0] res_a = '0, res_b = '0;
    logic        pair_sel = 1'b0, ser_mode = 1'b0, chan_a_sel = 1'b0;
    logic        swap_bytes = 1'b0, cs_n = 1'b1, rd_n = 1'b1;
    logic        ext_clk_sel = 1'b0, sync_inv = 1'b0, sclk_in = 1'b0;
    logic [1:0]  div_set = '0;
    logic [15:0] data_out;
    logic        data_oe, pair_tag, sdout, sclk_out, sync;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_result_port uut (
        .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_a(res_a),
        .res_b(res_b), .pair_sel(pair_sel), .ser_mode(ser_mode),
        .chan_a_sel(chan_a_sel), .swap_bytes(swap_bytes), .cs_n(cs_n),
        .rd_n(rd_n), .ext_clk_sel(ext_clk_sel), .sync_inv(sync_inv),
        .div_set(div_set), .sclk_in(sclk_in), .data_out(data_out),
        .data_oe(data_oe), .pair_tag(pair_tag), .sdout(sdout),
        .sclk_out(sclk_out), .sync(sync)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // strobe a pair in at the next edge; returns at the negedge after it
    task automatic load(input logic [15:0] a, input logic [15:0] b, input logic tag);
        @(negedge clk);
        res_a = a; res_b = b; pair_sel = tag; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        #1;
    endtask

    task automatic run_master(input logic [15:0] a, input logic [15:0] b,
                              input logic ord, input logic inv, input int n);
        logic [31:0] exp_f, got;
        int k, rises, first_rise, last_rise, bad_gap, active_cnt;
        bit prev;
        ser_mode = 1'b1; ext_clk_sel = 1'b0; chan_a_sel = ord;
        sync_inv = inv; div_set = 2'(n);
        exp_f = ord ? {a, b} : {b, a};
        load(a, b, 1'b0);
        k = 0; rises = 0; first_rise = -1; last_rise = -1; bad_gap = 0;
        active_cnt = 0; prev = 1'b0; got = '0;
        while (k < 4000) begin
            if (sync == inv) break;
            active_cnt++;
            if (sclk_out && !prev) begin
                if (first_rise < 0) first_rise = k;
                else if (k - last_rise != (2 << n)) bad_gap++;
                last_rise = k;
                got = {got[30:0], sdout};
                rises++;
            end
            prev = sclk_out;
            k++;
            @(negedge clk); #1;
        end
        check(got == exp_f, "R5 master frame bits", got, exp_f);
        check(first_rise == (1 << n), "R6 first rise cycle", first_rise, 1 << n);
        check(rises == 32 && bad_gap == 0, "R6 rise count/period", rises, 32);
        check(active_cnt == (64 << n), "R7 sync length", active_cnt, 64 << n);
        check(sync == inv, "R7 sync idle level", sync, inv);
    endtask

    task automatic run_slave(input logic [15:0] a, input logic [15:0] b,
                             input logic ord, input int n);
        logic [31:0] exp_f, got;
        bit noisy;
        ser_mode = 1'b1; ext_clk_sel = 1'b1; chan_a_sel = ord;
        sync_inv = 1'b1; div_set = 2'(n); sclk_in = 1'b0;
        exp_f = ord ? {a, b} : {b, a};
        load(a, b, 1'b1);
        got = '0; noisy = 1'b0;
        for (int i = 0; i < 32; i++) begin
            repeat (4) begin
                @(negedge clk); #1;
                if (sclk_out || sync) noisy = 1'b1;
            end
            got = {got[30:0], sdout};
            sclk_in = 1'b1;
            repeat (4) begin
                @(negedge clk); #1;
                if (sclk_out || sync) noisy = 1'b1;
            end
            sclk_in = 1'b0;
        end
        repeat (4) @(negedge clk);
        #1;
        check(got == exp_f, "R8 slave frame bits", got, exp_f);
        check(!noisy, "R9 slave sclk_out/sync quiet", noisy, 0);
        check(sdout == 1'b0, "R8 frame ended", sdout, 0);
    endtask

    initial begin
        logic [15:0] va [2];
        logic [15:0] vb [2];
        logic [15:0] pick, want;
        va[0] = 16'hA55A; vb[0] = 16'h3C81;
        va[1] = 16'h0F12; vb[1] = 16'hE7D4;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R10 reset state
        check(data_oe == 0 && data_out == 0, "R10 bus idle", data_out, 0);
        check(sdout == 0 && sclk_out == 0 && sync == 0, "R10 serial idle",
              {sdout, sclk_out, sync}, 0);
        check(pair_tag == 0, "R10 tag", pair_tag, 0);

        // parallel sweep
        for (int s = 0; s < 2; s++) begin
            ser_mode = 1'b0;
            load(va[s], vb[s], 1'(s));
            check(pair_tag == 1'(s), "R1 tag latched", pair_tag, s);
            for (int c = 0; c < 2; c++) begin
                for (int w = 0; w < 2; w++) begin
                    for (int g = 0; g < 4; g++) begin
                        @(negedge clk);
                        chan_a_sel = 1'(c); swap_bytes = 1'(w);
                        cs_n = g[0]; rd_n = g[1];
                        #1;
                        if (g == 0) begin
                            pick = c ? va[s] : vb[s];
                            want = w ? {pick[7:0], pick[15:8]} : pick;
                            check(data_oe == 1, "R2 oe on read", data_oe, 1);
                            check(data_out == want, w ? "R4 swapped word" : "R3 channel word",
                                  data_out, want);
                        end else begin
                            check(data_oe == 0 && data_out == 0, "R2 oe off",
                                  data_out, 0);
                        end
                    end
                end
            end
        end
        // R2 serial mode keeps bus off even with a read
        @(negedge clk); ser_mode = 1'b1; cs_n = 1'b0; rd_n = 1'b0; #1;
        check(data_oe == 0, "R2 serial mode bus off", data_oe, 0);
        cs_n = 1'b1; rd_n = 1'b1;

        // master sweep
        for (int n = 0; n < 4; n++)
            for (int o = 0; o < 2; o++)
                for (int p = 0; p < 2; p++)
                    run_master(va[o ^ p], vb[p], 1'(o), 1'(p), n);

        // slave with two divider settings (R9: setting unused)
        run_slave(va[0], vb[0], 1'b1, 0);
        run_slave(va[0], vb[0], 1'b1, 3);
        run_slave(va[1], vb[1], 1'b0, 2);

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule